// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Bank

This block is the digital front end of a four-channel, 12-bit digital-to-analog converter. A host reaches it over a small parallel bus: a 12-bit bidirectional data port, a 2-bit channel address, an active-low chip select and a read/write line (high reads, low writes). Every channel has two registers. The staging register takes bus writes. The code register feeds the converter. The four code registers leave the block as one flat vector of converter codes.

An active-low load-all strobe copies every staging register into its code register together, so all four channels can change on the same clock edge. If a write arrives while the load is active, the written word goes straight through to the code register of its channel. Readback always returns the staging register. An active-low reset returns the code registers to a code picked by a parameter: midscale 0x800 or zero 0x000. Reset leaves the staging registers alone.

The load and reset inputs are asynchronous. Each one passes through a two-flop synchronizer before it acts. Bus writes are sampled on the rising edge of the block clock. Readback drives the data port combinationally for as long as a read is selected.

Top module: `quad_dac_regbank`

## Requirements
- R1: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel k appears on `dacCode[12k+11:12k]`, with bit 11 as the MSB. All codes are straight binary.
- R2: While `csN` is high, a write cycle changes no staging register and no code register, and the data port is not driven.
- R3: A write (`csN` low, `rwN` low) with the load inactive stores the data word in the addressed staging register on that clock edge. All four codes stay the same.
- R4: A read (`csN` low, `rwN` high) drives the addressed staging register onto the data port, not the code register. A read changes no register.
- R5: Taking `loadN` low copies all four staging registers into the code registers. The copy lands on the third rising edge after `loadN` is first sampled low, and not on an earlier edge.
- R6: A write during a cycle in which the synchronized load is active places the written word in that channel's code register on the same edge as it enters the staging register.
- R7: `rstN` low forces every code register to the reset code on the next rising edge, whatever `csN` is doing. The reset code is 0x800 when `RESET_MIDSCALE` is 1 and 0x000 when it is 0. Staging registers keep their contents.
- R8: Reset overrides the load. While `loadN` is held low, the codes stay at the reset code until the second rising edge after `rstN` rises. The load copies the staging registers again on the third edge.
- R9: `busOe` is high and the block drives the data port only during a selected read. At all other times the port is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the code registers |
| csN | input | 1 | Active-low chip select |
| rwN | input | 1 | High reads, low writes |
| addr | input | 2 | Channel address |
| loadN | input | 1 | Asynchronous active-low load-all strobe |
| data | inout | 12 | Bidirectional data port |
| busOe | output | 1 | High while the block drives `data` |
| dacCode | output | 48 | Four 12-bit converter codes, channel A in the low bits |

## Verification
The properties assume that `csN`, `rwN`, `addr` and the write data are synchronous to `clk` and stable around each rising edge. They also assume that `rstN` is low at time zero, so the load synchronizer, which has no reset, is masked until it carries real values. The stimulus changes every bus input only on falling edges. It holds the reset from the first cycle, and it writes all four staging registers before the first load, so no copy ever moves an unwritten value. The load and reset strobes are driven on falling edges as well. This makes their synchronizer latency deterministic, and the bench checks exact edges against it.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Strobes passed from the control unit to the register datapath.
  typedef struct packed {
    logic wrEn;      // selected write cycle
    logic rdEn;      // selected read cycle
    logic loadAll;   // synchronized load, already masked by reset
    logic clearAll;  // synchronized reset of the code registers
  } ctrlStrobe_t;

endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rwN,
  input  logic        loadN,
  output ctrlStrobe_t strobe
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] rstPipe;
  logic [SYNC_STAGES-1:0] loadPipe;
  logic                   clearLive;

  // Reset synchronizer: asserts at once, releases after SYNC_STAGES edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[TOP-1:0], 1'b1};
  end

  // Load synchronizer: plain flop chain, gated by the reset below.
  always_ff @(posedge clk) begin
    loadPipe <= {loadPipe[TOP-1:0], loadN};
  end

  assign clearLive = ~rstPipe[TOP];

  always_comb begin
    strobe.clearAll = clearLive;
    strobe.loadAll  = ~loadPipe[TOP] & ~clearLive;
    strobe.wrEn     = ~csN & ~rwN;
    strobe.rdEn     = ~csN &  rwN;
  end

endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int              DATA_W     = 12,
  parameter int              NUM_CH     = 4,
  parameter int              ADDR_W     = 2,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input  logic                     clk,
  input  ctrlStrobe_t              strobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH*DATA_W-1:0] stageFlat,
  output logic [NUM_CH*DATA_W-1:0] codeFlat
);

  logic [DATA_W-1:0] stageReg [NUM_CH];
  logic [DATA_W-1:0] codeReg  [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic chanHit;
    assign chanHit = strobe.wrEn && (addr == ADDR_W'(ch));

    always_ff @(posedge clk) begin
      if (chanHit) stageReg[ch] <= wrData;
    end

    always_ff @(posedge clk) begin
      if (strobe.clearAll)     codeReg[ch] <= RESET_CODE;
      else if (strobe.loadAll) codeReg[ch] <= chanHit ? wrData : stageReg[ch];
    end

    assign stageFlat[ch*DATA_W +: DATA_W] = stageReg[ch];
    assign codeFlat [ch*DATA_W +: DATA_W] = codeReg[ch];
  end

  assign rdData = stageReg[addr];

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
  import qdac_pkg::*;
#(
  parameter int DATA_W         = 12,
  parameter int NUM_CH         = 4,
  parameter bit RESET_MIDSCALE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rwN,
  input  logic [1:0]               addr,
  input  logic                     loadN,
  inout  wire  [DATA_W-1:0]        data,
  output logic                     busOe,
  output logic [NUM_CH*DATA_W-1:0] dacCode
);

  localparam int ADDR_W = 2;
  localparam logic [DATA_W-1:0] RESET_CODE =
    RESET_MIDSCALE ? DATA_W'(1) << (DATA_W - 1) : '0;

  ctrlStrobe_t               strobe;
  logic [DATA_W-1:0]         rdData;
  logic [NUM_CH*DATA_W-1:0]  stageFlat;

  qdac_ctrl #(.SYNC_STAGES(2)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .rwN   (rwN),
    .loadN (loadN),
    .strobe(strobe)
  );

  qdac_datapath #(
    .DATA_W    (DATA_W),
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .RESET_CODE(RESET_CODE)
  ) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (data),
    .rdData   (rdData),
    .stageFlat(stageFlat),
    .codeFlat (dacCode)
  );

  assign busOe = strobe.rdEn;
  assign data  = busOe ? rdData : 'z;

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
  import qdac_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter int                NUM_CH     = 4,
  parameter logic [DATA_W-1:0] RESET_CODE = '0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     csN,
  input logic                     rwN,
  input ctrlStrobe_t              strobe,
  input logic                     busOe,
  input logic [NUM_CH*DATA_W-1:0] stageFlat,
  input logic [NUM_CH*DATA_W-1:0] dacCode
);

  assert_oe_only_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!csN && rwN));

  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !strobe.loadAll && !strobe.clearAll) |=> ($stable(dacCode) && $stable(stageFlat)));

  assert_write_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.loadAll && !strobe.clearAll) |=> $stable(dacCode));

  assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !strobe.loadAll && !strobe.clearAll) |=> ($stable(dacCode) && $stable(stageFlat)));

  assert_load_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadAll && !strobe.wrEn) |=> (dacCode == $past(stageFlat)));

  // Reset code wins even when the load is pending (R8).
  assert_reset_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (dacCode == {NUM_CH{RESET_CODE}}));

endmodule

bind quad_dac_regbank qdac_checker #(
  .DATA_W    (DATA_W),
  .NUM_CH    (NUM_CH),
  .RESET_CODE(RESET_CODE)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rwN      (rwN),
  .strobe   (strobe),
  .busOe    (busOe),
  .stageFlat(stageFlat),
  .dacCode  (dacCode)
);

// File: tb/quad_dac_regbank_tb.sv
module quad_dac_regbank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int N = 4;
  localparam logic [W-1:0] RST_CODE = 12'h800;

  logic clk = 1'b0;
  logic rstN, csN, rwN, loadN, tbDrv, busOe;
  logic [1:0] addr;
  logic [W-1:0] tbData;
  logic [N*W-1:0] dacCode;
  wire  [W-1:0] dataBus;

  assign dataBus = tbDrv ? tbData : 'z;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_regbank #(.DATA_W(W), .NUM_CH(N), .RESET_MIDSCALE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rwN(rwN), .addr(addr),
    .loadN(loadN), .data(dataBus), .busOe(busOe), .dacCode(dacCode)
  );

  typedef struct {
    string        tag;
    int           lane;  // 0..3 code lane, 4 data port, 5 busOe
    logic [W-1:0] exp;
  } item_t;

  item_t        sbQ[$];
  event         checkEv;
  int           checks = 0;
  int           errors = 0;
  bit           done = 0;
  logic [W-1:0] expStage [N];
  logic [W-1:0] expCode  [N];

  // Monitor: pops expected items and compares them against the ports.
  initial begin
    forever begin
      @(checkEv);
      while (sbQ.size() > 0) begin
        item_t it;
        logic [W-1:0] got;
        it = sbQ.pop_front();
        if (it.lane < 4)       got = dacCode[it.lane*W +: W];
        else if (it.lane == 4) got = dataBus;
        else                   got = {{(W-1){1'b0}}, busOe};
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s lane %0d: got %h expected %h", it.tag, it.lane, got, it.exp);
        end
      end
    end
  end

  task automatic pushExp(string tag, int lane, logic [W-1:0] exp);
    item_t it;
    it.tag = tag; it.lane = lane; it.exp = exp;
    sbQ.push_back(it);
  endtask

  task automatic flushChecks();
    ->checkEv;
    #1;
  endtask

  task automatic checkCodes(string tag);
    for (int i = 0; i < N; i++) pushExp(tag, i, expCode[i]);
    flushChecks();
  endtask

  task automatic busWrite(int ch, logic [W-1:0] val);
    csN = 1'b0; rwN = 1'b0; addr = 2'(ch); tbData = val; tbDrv = 1'b1;
    @(negedge clk);
    csN = 1'b1; rwN = 1'b1; tbDrv = 1'b0;
    expStage[ch] = val;
  endtask

  task automatic busReadCheck(string tag, int ch);
    csN = 1'b0; rwN = 1'b1; addr = 2'(ch);
    #1;
    pushExp(tag, 4, expStage[ch]);
    pushExp(tag, 5, 12'h001);
    flushChecks();
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic copyAll();
    for (int i = 0; i < N; i++) expCode[i] = expStage[i];
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; rwN = 1'b1; loadN = 1'b1; tbDrv = 1'b0;
    addr = 2'd0; tbData = '0;
    for (int i = 0; i < N; i++) begin expStage[i] = 'x; expCode[i] = RST_CODE; end
    repeat (3) @(negedge clk);
    checkCodes("R7 reset code");
    pushExp("R9 idle port released", 5, 12'h000); flushChecks();
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R3: fill each channel, codes hold while the load is idle.
    busWrite(0, 12'h123);
    busWrite(1, 12'h456);
    busWrite(2, 12'h789);
    busWrite(3, 12'hABC);
    checkCodes("R3 codes hold on write");
    for (int i = 0; i < N; i++) busReadCheck("R1 address map readback", i);

    // R2: a write with chip select high is ignored and the port stays released.
    csN = 1'b1; rwN = 1'b0; addr = 2'd1; tbData = 12'hFFF; tbDrv = 1'b1;
    #1;
    pushExp("R2 port released while deselected", 5, 12'h000); flushChecks();
    @(negedge clk);
    rwN = 1'b1; tbDrv = 1'b0;
    busReadCheck("R2 deselected write ignored", 1);
    checkCodes("R2 codes unchanged");

    // R5: load latency through the two-flop synchronizer.
    loadN = 1'b0;
    @(negedge clk);
    loadN = 1'b1;
    @(negedge clk);
    checkCodes("R5 no update before third edge");
    @(negedge clk);
    copyAll();
    checkCodes("R5 all channels copied");

    // R4: readback shows the staging register, not the code register.
    busWrite(0, 12'h0F0);
    checkCodes("R3 code A holds after write");
    busReadCheck("R4 readback from staging", 0);
    pushExp("R4 code A still old", 0, 12'h123); flushChecks();

    // R6: write while the load is held active goes straight to the code.
    loadN = 1'b0;
    repeat (3) @(negedge clk);
    copyAll();
    checkCodes("R5 held load copies");
    busWrite(2, 12'h5A5);
    expCode[2] = 12'h5A5;
    checkCodes("R6 forwarded write");

    // R7 / R8: reset during an active load.
    rstN = 1'b0;
    @(negedge clk);
    for (int i = 0; i < N; i++) expCode[i] = RST_CODE;
    checkCodes("R8 reset over load");
    busReadCheck("R7 staging survives reset", 0);
    busReadCheck("R7 staging C survives reset", 2);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkCodes("R8 reset window holds");
    @(negedge clk);
    copyAll();
    checkCodes("R8 load resumes after reset");
    loadN = 1'b1;
    repeat (3) @(negedge clk);

    busReadCheck("R1 channel D readback", 3);
    pushExp("R9 port released after read", 5, 12'h000); flushChecks();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule